// File: doc/BRIEF.md
# Synthesizer Serial Configuration Sequencer

This block sets up an external integer-N frequency synthesizer through a three-wire serial port: a data line, a serial clock and a latch strobe. When `start` is pulsed, it captures its static configuration inputs and shifts three 21-bit words, most significant bit first. The words go out in a fixed order: a function word, a reference-divider word and a feedback-divider word. After the last bit of each word, the latch strobe pulses once to commit that word.

The feedback word is computed from one requested divide ratio N. N is split into a swallow count A (N mod 8) and a main count B (N div 8), which suits a divide-by-8/9 dual-modulus prescaler. The function word carries 19 configuration bits. The reference word carries the reference divide ratio.

After programming, the block supervises lock. It waits a programmable number of cycles and then samples a two-flop synchronized copy of the active-high lock-detect input. If lock is present, it waits again. If lock is missing, it reprograms all three words from freshly sampled inputs. No data stream passes through the block, so every pin is a plain control or status signal and no valid/ready handshake is used.

Top module: `pll_prog_seq`

## Requirements
- R1: While reset is active and right after it, `ser_clk`, `ser_data`, `ser_le`, `busy` and `locked` are all low.
- R2: Each sequence sends three words in this order: function word, then reference word, then feedback word. Each word has 21 bits, most significant bit first, and the device samples each bit on the rising edge of `ser_clk`.
- R3: Bits [1:0] of every word are its address code. The function word is `{func_cfg[18:0], 2'b11}`. The reference word is `{5'b0, ref_div[13:0], 2'b00}`, so a reference ratio of 4 gives a low byte of 8'h10.
- R4: The feedback word is `{1'b1, B[12:0], A[4:0], 2'b01}`, where A = N mod 8 (so A[4:3] is 0) and B = N div 8. N = 110 gives 21'h100699.
- R5: `ser_clk` stays high for exactly SCK_HALF system cycles per bit, with a default of 2. `ser_data` does not change while `ser_clk` is high.
- R6: `ser_le` pulses high only while `ser_clk` is low, and only after exactly 21 rising edges of `ser_clk` since the previous pulse.
- R7: `busy` rises in the cycle after an accepted `start`. It stays high until the third latch pulse is over, and the three latch pulses all fall inside that window.
- R8: After a sequence, the block waits `wait_cycles` cycles and then polls lock. While lock is present, no further words are sent. When lock is missing at a poll, all three words are sent again.
- R9: `locked` equals `lock_det` delayed by two system-clock registers.
- R10: `func_cfg`, `ref_div` and `n_div` are captured only when a sequence starts. A change during a sequence takes effect at the next reload.
- R11: A `start` pulse while `busy` is high is ignored. The sequence in progress is not restarted and no extra words are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to program the synthesizer |
| func_cfg | input | 19 | Function word configuration bits |
| ref_div | input | 14 | Reference divide ratio |
| n_div | input | 16 | Total feedback divide ratio N |
| wait_cycles | input | 16 | Cycles between the end of programming and each lock poll |
| lock_det | input | 1 | Active-high lock detect from the synthesizer |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| ser_le | output | 1 | Latch-enable strobe |
| busy | output | 1 | High while words are being shifted |
| locked | output | 1 | Synchronized lock detect |

## Verification
A wrong word index or a missed shift step appears on the wire immediately. The word decoded at the next latch pulse, within about 88 system cycles, carries a wrong address code or a bit pattern shifted by one position. A bad divide split shows up as a feedback word that differs from the value computed in the bench for that N, including near the 8-boundary values 7, 8 and 0xFFFF. Faults in the lock supervisor take longer to show. They appear within one wait interval plus two synchronizer cycles, either as extra words sent while lock is held or as no words sent when lock drops.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;
  localparam int WORD_W     = 21;
  localparam int A_FIELD_W  = 5;
  localparam int B_FIELD_W  = 13;
  localparam int PRESC_LOG2 = 3;
  localparam int NUM_WORDS  = 3;

  localparam logic [1:0] ADDR_FUNC = 2'b11;
  localparam logic [1:0] ADDR_REF  = 2'b00;
  localparam logic [1:0] ADDR_FDBK = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_SEND, ST_WAIT} seq_state_t;
  typedef enum logic [1:0] {PH_SETUP, PH_HIGH, PH_GAP, PH_LATCH} ser_phase_t;
endpackage

// File: rtl/pll_word_builder.sv
module pll_word_builder
  import pll_prog_pkg::*;
#(
  parameter int FUNC_W = 19,
  parameter int REF_W  = 14,
  parameter int N_W    = 16
) (
  input  logic [FUNC_W-1:0] func_cfg,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [N_W-1:0]    n_div,
  input  logic [1:0]        word_idx,
  output logic [WORD_W-1:0] word
);
  localparam int REF_PAD = WORD_W - 2 - REF_W;
  localparam int A_PAD   = A_FIELD_W - PRESC_LOG2;

  logic [A_FIELD_W-1:0] swallow;
  logic [B_FIELD_W-1:0] main_cnt;
  logic [WORD_W-1:0]    w_func, w_ref, w_fdbk;

  always_comb begin
    swallow  = {{A_PAD{1'b0}}, n_div[PRESC_LOG2-1:0]};
    main_cnt = n_div[N_W-1:PRESC_LOG2];
    w_func   = {func_cfg, ADDR_FUNC};
    w_ref    = {{REF_PAD{1'b0}}, ref_div, ADDR_REF};
    w_fdbk   = {1'b1, main_cnt, swallow, ADDR_FDBK};
    case (word_idx)
      2'd0:    word = w_func;
      2'd1:    word = w_ref;
      default: word = w_fdbk;
    endcase
  end
endmodule

// File: rtl/pll_ser_shifter.sv
module pll_ser_shifter
  import pll_prog_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] word,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le,
  output logic              done
);
  localparam int HC_W  = $clog2(SCK_HALF + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);

  ser_phase_t        ph;
  logic              active;
  logic [WORD_W-1:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic [HC_W-1:0]   hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_SETUP; active <= 1'b0; shreg <= '0;
      bitcnt <= '0; hc <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1; shreg <= word; bitcnt <= '0;
        hc <= '0; ph <= PH_SETUP;
      end else if (active) begin
        if (hc == HC_W'(SCK_HALF - 1)) begin
          hc <= '0;
          case (ph)
            PH_SETUP: ph <= PH_HIGH;
            PH_HIGH: begin
              if (bitcnt == BIT_W'(WORD_W - 1)) ph <= PH_GAP;
              else begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[WORD_W-2:0], 1'b0};
                ph     <= PH_SETUP;
              end
            end
            PH_GAP:   ph <= PH_LATCH;
            default: begin
              active <= 1'b0; done <= 1'b1; ph <= PH_SETUP;
            end
          endcase
        end else begin
          hc <= hc + 1'b1;
        end
      end
    end
  end

  assign ser_data = active && (ph == PH_SETUP || ph == PH_HIGH) && shreg[WORD_W-1];
  assign ser_clk  = active && (ph == PH_HIGH);
  assign ser_le   = active && (ph == PH_LATCH);

  // checker state: rising edges of ser_clk since the last latch pulse
  logic             sck_d;
  logic [BIT_W-1:0] edge_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; edge_cnt <= '0;
    end else begin
      sck_d <= ser_clk;
      if (ser_le) edge_cnt <= '0;
      else if (ser_clk && !sck_d) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assert_le_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);
  assert_le_after_21_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_le) |-> edge_cnt == BIT_W'(WORD_W));
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  assert_clk_high_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> $past(ser_clk, 2));
endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end
  assign dout = chain[STAGES-1];

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end
  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> dout == $past(din, 2));
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_prog_pkg::*;
#(
  parameter int FUNC_W   = 19,
  parameter int REF_W    = 14,
  parameter int N_W      = 16,
  parameter int WAIT_W   = 16,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FUNC_W-1:0] func_cfg,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [N_W-1:0]    n_div,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic              lock_det,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le,
  output logic              busy,
  output logic              locked
);
  seq_state_t        st;
  logic [1:0]        idx;
  logic [WAIT_W-1:0] wcnt;
  logic [FUNC_W-1:0] func_q;
  logic [REF_W-1:0]  ref_q;
  logic [N_W-1:0]    n_q;
  logic [WORD_W-1:0] cur_word;
  logic              sh_done, lock_s, go;

  pll_word_builder #(.FUNC_W(FUNC_W), .REF_W(REF_W), .N_W(N_W)) u_build (
    .func_cfg(func_q), .ref_div(ref_q), .n_div(n_q),
    .word_idx(idx), .word(cur_word));

  assign go = (st == ST_ISSUE);

  pll_ser_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .word(cur_word),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le), .done(sh_done));

  pll_lock_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(lock_det), .dout(lock_s));

  assign locked = lock_s;
  assign busy   = (st == ST_ISSUE) || (st == ST_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; idx <= '0; wcnt <= '0;
      func_q <= '0; ref_q <= '0; n_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          func_q <= func_cfg; ref_q <= ref_div; n_q <= n_div;
          idx <= '0; st <= ST_ISSUE;
        end
        ST_ISSUE: st <= ST_SEND;
        ST_SEND: if (sh_done) begin
          if (idx == 2'(NUM_WORDS - 1)) begin
            st <= ST_WAIT; wcnt <= '0;
          end else begin
            idx <= idx + 1'b1; st <= ST_ISSUE;
          end
        end
        default: begin
          if (start || (wcnt >= wait_cycles && !lock_s)) begin
            func_q <= func_cfg; ref_q <= ref_div; n_q <= n_div;
            idx <= '0; st <= ST_ISSUE;
          end else if (wcnt >= wait_cycles) begin
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      endcase
    end
  end

  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_le));
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND && !sh_done) |=> (st == ST_SEND && $stable(idx)));
  assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(n_q) && $stable(ref_q) && $stable(func_q)));
  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> idx == 2'd0);
endmodule

// File: tb/pll_prog_seq_tb.sv
module pll_prog_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lock_det = 1'b1;
  logic [18:0] func_cfg = '0;
  logic [13:0] ref_div = '0;
  logic [15:0] n_div = '0;
  logic [15:0] wait_cycles = 16'd20;
  logic ser_data, ser_clk, ser_le, busy, locked;

  always #2 clk = ~clk;

  pll_prog_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .func_cfg(func_cfg),
    .ref_div(ref_div), .n_div(n_div), .wait_cycles(wait_cycles), .lock_det(lock_det),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le), .busy(busy), .locked(locked));

  int unsigned n_checks = 0, n_fail = 0;

  function automatic logic [20:0] exp_func(input logic [18:0] f);
    return {f, 2'b11};
  endfunction
  function automatic logic [20:0] exp_ref(input logic [13:0] r);
    return {5'b0, r, 2'b00};
  endfunction
  function automatic logic [20:0] exp_fdbk(input logic [15:0] n);
    logic [15:0] b = n / 16'd8;
    logic [15:0] a = n % 16'd8;
    return {1'b1, b[12:0], a[4:0], 2'b01};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // wire monitor, sampled at the falling edge of the system clock
  logic [20:0] cap [0:63];
  int unsigned wcount = 0, hmin = 999, hmax = 0, hrun = 0, hold_bad = 0;
  logic [20:0] acc = '0;
  logic sck_p = 1'b0, le_p = 1'b0, dat_p = 1'b0;
  always @(negedge clk) begin
    if (ser_clk && !sck_p) acc = {acc[19:0], ser_data};
    if (ser_clk && sck_p && ser_data != dat_p) hold_bad++;
    if (ser_clk) hrun++;
    else if (sck_p) begin
      if (hrun < hmin) hmin = hrun;
      if (hrun > hmax) hmax = hrun;
      hrun = 0;
    end
    if (ser_le && !le_p) begin
      cap[wcount % 64] = acc;
      wcount++;
    end
    sck_p = ser_clk; le_p = ser_le; dat_p = ser_data;
  end

  task automatic wait_words(input int unsigned target);
    while (wcount < target) @(negedge clk);
  endtask

  task automatic check_seq(input int unsigned base, input logic [18:0] f,
                           input logic [13:0] r, input logic [15:0] n, input string req);
    check({req, " R2 R3 function word"}, 32'(cap[base % 64]), 32'(exp_func(f)));
    check({req, " R2 R3 reference word"}, 32'(cap[(base + 1) % 64]), 32'(exp_ref(r)));
    check({req, " R2 R4 feedback word"}, 32'(cap[(base + 2) % 64]), 32'(exp_fdbk(n)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    int unsigned base;
    seed = $urandom(32'd4321);
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    check("R1 outputs in reset", {27'd0, ser_clk, ser_data, ser_le, busy, locked}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", {27'd0, ser_clk, ser_data, ser_le, busy, locked}, 32'd0);

    // directed: ref 4, N 110, mid-sequence input change and start
    func_cfg = 19'h0002C; ref_div = 14'd4; n_div = 16'd110;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R7 busy after start", {31'd0, busy}, 32'd1);
    repeat (120) @(negedge clk);
    n_div = 16'd200; ref_div = 14'd5;            // R10: must not affect this sequence
    start = 1'b1; @(negedge clk); start = 1'b0;  // R11: ignored while busy
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R7 R11 three words per sequence", wcount, 32'd3);
    check_seq(0, 19'h0002C, 14'd4, 16'd110, "R10");
    check("R4 N=110 word", 32'(cap[2]), 32'h100699);
    check("R3 reference low byte", {24'd0, cap[1][7:0]}, 32'h10);
    check("R5 clock high min", hmin, 32'd2);
    check("R5 clock high max", hmax, 32'd2);
    check("R5 data stable while clock high", hold_bad, 32'd0);

    // R8: lock held, no reprogramming over many poll intervals
    repeat (300) @(negedge clk);
    check("R8 no reload while locked", wcount, 32'd3);
    check("R9 locked follows lock_det", {31'd0, locked}, 32'd1);

    // R8 R10: lock lost, reload uses new values
    lock_det = 1'b0;
    wait_words(6);
    lock_det = 1'b1;
    check_seq(3, 19'h0002C, 14'd5, 16'd200, "R8 R10 reload");
    while (busy) @(negedge clk);
    repeat (100) @(negedge clk);
    check("R8 single reload", wcount, 32'd6);

    // corners of the divide split and random patterns
    for (int i = 0; i < 10; i++) begin
      logic [15:0] n;
      logic [13:0] r;
      logic [18:0] f;
      case (i)
        0: n = 16'd7;
        1: n = 16'd8;
        2: n = 16'hFFFF;
        default: n = 16'($urandom);
      endcase
      r = 14'($urandom);
      f = 19'($urandom);
      n_div = n; ref_div = r; func_cfg = f;
      base = wcount;
      lock_det = 1'b0;
      wait_words(base + 3);
      lock_det = 1'b1;
      check_seq(base, f, r, n, "R4 random");
      while (busy) @(negedge clk);
      repeat (40) @(negedge clk);
    end
    check("R6 R2 words framed on wire", wcount, 32'd36);

    // R9: two-register delay on lock detect
    repeat (5) @(negedge clk);
    lock_det = 1'b0;
    @(negedge clk);
    check("R9 locked after one cycle", {31'd0, locked}, 32'd1);
    @(negedge clk);
    check("R9 locked after two cycles", {31'd0, locked}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule